// File: doc/BRIEF.md
# Per-Field Half-Operand Operand Fetch Stage

This block prepares the two source operands of a 128-bit SWAR datapath before they reach the execution unit. The register vector is split into fields whose width is a power of two, anywhere from 2 up to 128 bits. Each operand carries its own half selector. The selector can leave the operand unchanged, take the upper half of every field, or take the lower half of every field. Either half ends up right-aligned in its field, and the other half of the field is cleared. The execution unit then sees, for example, the upper and lower halves of each pair as two independent operands. That lets it combine neighbouring fields and build results at double the field width.

A strict-pairing input selects a cheaper operating rule. In that rule, only the first operand may select the upper half and only the second operand may select the lower half. A request that breaks the rule raises an error flag, and both operands then go through untouched. The selection logic is combinational and is followed by one output register, so results appear one clock after the inputs are presented.

Top module: `hom_fetch`

## Requirements
- R1: While `rst_n` is low, `res_a`, `res_b` and `bad_combo` are all zero.
- R2: Outputs reflect the inputs present at the previous rising clock edge (one cycle of latency). Before that edge, the outputs keep their old values.
- R3: A selector code of 0 (pass) or 3 (reserved) passes the operand through unchanged.
- R4: Selector code 1 (upper) places the upper half of each field into the lower half of the same field and zeroes the upper half.
- R5: Selector code 2 (lower) keeps the lower half of each field and zeroes the upper half.
- R6: `fw_code` values 1 to 7 select a field width of 2 to the power `fw_code` bits (2 to 128). A value of 0 disables every modification, so both operands pass through.
- R7: When `strict` is 0, each operand applies its selector independently, including both-upper and both-lower, and `bad_combo` stays 0.
- R8: When `strict` is 1, `bad_combo` is 1 exactly when `sel_a` is 2 (lower) or `sel_b` is 1 (upper). So both-upper and both-lower requests are flagged.
- R9: When `bad_combo` is set, `res_a` and `res_b` equal the unmodified operands.
- R10: At `fw_code` 7, the pair upper-on-first and lower-on-second places the two 64-bit halves right-aligned in separate outputs with zeroed upper halves.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| op_a | input | 128 | First source operand |
| op_b | input | 128 | Second source operand |
| fw_code | input | 3 | Field width code (0 = no modification, n = 2^n bits) |
| sel_a | input | 2 | Half selector for first operand (0 pass, 1 upper, 2 lower, 3 pass) |
| sel_b | input | 2 | Half selector for second operand (same encoding) |
| strict | input | 1 | Restricted pairing rule enable |
| res_a | output | 128 | Prepared first operand, registered |
| res_b | output | 128 | Prepared second operand, registered |
| bad_combo | output | 1 | Illegal selector pairing in restricted rule, registered |

## Verification
The stage has no state beyond its output register, so any wrong selection shows up on the very next cycle at `res_a`, `res_b` or `bad_combo`. A mask built for the wrong field width makes bits vanish or survive at the field boundaries. A wrong shift amount moves data into the wrong bit lanes. A flawed legality decode either flags a legal pair or lets a modified value through when it should be bypassed. Random operands over every width code and selector pair, compared against an independent per-bit model, expose each of these within one transaction.

// File: rtl/hom_pkg.sv
package hom_pkg;
  localparam int unsigned DATA_W = 128;
  localparam int unsigned CODE_W = $clog2($clog2(DATA_W) + 1);

  typedef enum logic [1:0] {
    SEL_PASS  = 2'd0,
    SEL_UPPER = 2'd1,
    SEL_LOWER = 2'd2,
    SEL_RSVD  = 2'd3
  } half_sel_e;
endpackage

// File: rtl/hom_mask_gen.sv
// Builds a lane mask: bit set where the bit lies in the lower half of its field.
module hom_mask_gen #(
  parameter int unsigned DATA_W = hom_pkg::DATA_W,
  parameter int unsigned CODE_W = hom_pkg::CODE_W
) (
  input  logic [CODE_W-1:0] fw_code,
  output logic [DATA_W-1:0] lo_mask
);
  localparam int unsigned MAX_CODE = $clog2(DATA_W);

  generate
    for (genvar gi = 0; gi < DATA_W; gi++) begin : g_lane
      logic lane_lo;
      always_comb begin
        lane_lo = 1'b1;
        if (fw_code != '0 && int'(fw_code) <= MAX_CODE) begin
          lane_lo = (((gi >> (int'(fw_code) - 1)) & 1) == 0);
        end
      end
      assign lo_mask[gi] = lane_lo;
    end
  endgenerate
endmodule

// File: rtl/hom_operand_mod.sv
// Applies one operand's half selector using the shared lane mask.
module hom_operand_mod
  import hom_pkg::*;
#(
  parameter int unsigned DATA_W = hom_pkg::DATA_W,
  parameter int unsigned CODE_W = hom_pkg::CODE_W
) (
  input  logic [DATA_W-1:0] op_in,
  input  logic [DATA_W-1:0] lo_mask,
  input  logic [CODE_W-1:0] fw_code,
  input  logic [1:0]        sel,
  input  logic              bypass,
  output logic [DATA_W-1:0] op_out
);
  logic [DATA_W-1:0] moved_down;
  logic [CODE_W-1:0] half_exp;

  assign half_exp = fw_code - CODE_W'(1);

  always_comb begin
    moved_down = op_in >> (32'd1 << half_exp);
  end

  always_comb begin
    op_out = op_in;
    if (!bypass && fw_code != '0) begin
      unique case (half_sel_e'(sel))
        SEL_UPPER: op_out = moved_down & lo_mask;
        SEL_LOWER: op_out = op_in & lo_mask;
        default:   op_out = op_in;
      endcase
    end
  end
endmodule

// File: rtl/hom_pair_check.sv
// Legality of the selector pair under the restricted pairing rule.
module hom_pair_check
  import hom_pkg::*;
(
  input  logic [1:0] sel_a,
  input  logic [1:0] sel_b,
  input  logic       strict,
  output logic       bad
);
  logic a_wrong, b_wrong;

  always_comb begin
    a_wrong = (half_sel_e'(sel_a) == SEL_LOWER);
    b_wrong = (half_sel_e'(sel_b) == SEL_UPPER);
    bad     = strict && (a_wrong || b_wrong);
  end
endmodule

// File: rtl/hom_fetch.sv
module hom_fetch
  import hom_pkg::*;
#(
  parameter int unsigned DATA_W = hom_pkg::DATA_W,
  parameter int unsigned CODE_W = hom_pkg::CODE_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [DATA_W-1:0] op_a,
  input  logic [DATA_W-1:0] op_b,
  input  logic [CODE_W-1:0] fw_code,
  input  logic [1:0]        sel_a,
  input  logic [1:0]        sel_b,
  input  logic              strict,
  output logic [DATA_W-1:0] res_a,
  output logic [DATA_W-1:0] res_b,
  output logic              bad_combo
);
  localparam int unsigned N_OPS = 2;

  logic [DATA_W-1:0] lo_mask;
  logic              bad_nxt;
  logic [DATA_W-1:0] src   [N_OPS];
  logic [1:0]        sel_v [N_OPS];
  logic [DATA_W-1:0] mod_v [N_OPS];

  assign src[0]   = op_a;
  assign src[1]   = op_b;
  assign sel_v[0] = sel_a;
  assign sel_v[1] = sel_b;

  hom_mask_gen #(.DATA_W(DATA_W), .CODE_W(CODE_W)) i_mask (
    .fw_code (fw_code),
    .lo_mask (lo_mask)
  );

  hom_pair_check i_pair (
    .sel_a  (sel_a),
    .sel_b  (sel_b),
    .strict (strict),
    .bad    (bad_nxt)
  );

  generate
    for (genvar go = 0; go < N_OPS; go++) begin : g_op
      hom_operand_mod #(.DATA_W(DATA_W), .CODE_W(CODE_W)) i_mod (
        .op_in   (src[go]),
        .lo_mask (lo_mask),
        .fw_code (fw_code),
        .sel     (sel_v[go]),
        .bypass  (bad_nxt),
        .op_out  (mod_v[go])
      );
    end
  endgenerate

  // Output register stage
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      res_a     <= '0;
      res_b     <= '0;
      bad_combo <= 1'b0;
    end else begin
      res_a     <= mod_v[0];
      res_b     <= mod_v[1];
      bad_combo <= bad_nxt;
    end
  end
endmodule

// File: rtl/hom_fetch_chk.sv
module hom_fetch_chk #(
  parameter int unsigned DATA_W = 128,
  parameter int unsigned CODE_W = 3
) (
  input logic              clk,
  input logic              rst_n,
  input logic [DATA_W-1:0] op_a,
  input logic [DATA_W-1:0] op_b,
  input logic [CODE_W-1:0] fw_code,
  input logic [1:0]        sel_a,
  input logic [1:0]        sel_b,
  input logic              strict,
  input logic [DATA_W-1:0] res_a,
  input logic [DATA_W-1:0] res_b,
  input logic              bad_combo
);
  localparam int unsigned HALF = DATA_W / 2;
  logic primed;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) primed <= 1'b0;
    else        primed <= 1'b1;
  end

  AST_RESET_ZERO: assert property (@(posedge clk)
    !rst_n |-> (res_a == '0 && res_b == '0 && !bad_combo)); // R1

  AST_FULL_NO_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    (primed && !$past(strict)) |-> !bad_combo); // R7

  AST_STRICT_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    (primed && $past(strict) && $past(sel_a) == 2'd1 && $past(sel_b) == 2'd2)
      |-> !bad_combo); // R8

  AST_BAD_BYPASS: assert property (@(posedge clk) disable iff (!rst_n)
    (primed && bad_combo) |-> (res_a == $past(op_a) && res_b == $past(op_b))); // R9

  AST_PASS_SEL: assert property (@(posedge clk) disable iff (!rst_n)
    (primed && ($past(sel_a) == 2'd0 || $past(sel_a) == 2'd3))
      |-> res_a == $past(op_a)); // R3

  AST_NO_WIDTH: assert property (@(posedge clk) disable iff (!rst_n)
    (primed && $past(fw_code) == '0) |-> (res_a == $past(op_a) && res_b == $past(op_b))); // R6

  AST_JOIN_HALVES: assert property (@(posedge clk) disable iff (!rst_n)
    (primed && $past(fw_code) == CODE_W'($clog2(DATA_W)) && $past(sel_a) == 2'd1
     && $past(sel_b) == 2'd2)
      |-> (res_a[DATA_W-1:HALF] == '0 && res_b[DATA_W-1:HALF] == '0
           && res_a[HALF-1:0] == $past(op_a[DATA_W-1:HALF])
           && res_b[HALF-1:0] == $past(op_b[HALF-1:0]))); // R10
endmodule

bind hom_fetch hom_fetch_chk #(.DATA_W(DATA_W), .CODE_W(CODE_W)) i_hom_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .op_a      (op_a),
  .op_b      (op_b),
  .fw_code   (fw_code),
  .sel_a     (sel_a),
  .sel_b     (sel_b),
  .strict    (strict),
  .res_a     (res_a),
  .res_b     (res_b),
  .bad_combo (bad_combo)
);

// File: tb/test_hom_fetch.sv
`timescale 1ns/1ps
module test_hom_fetch;
  localparam int DW = 128;

  logic          clk = 1'b0;
  logic          rst_n;
  logic [DW-1:0] op_a, op_b;
  logic [2:0]    fw_code;
  logic [1:0]    sel_a, sel_b;
  logic          strict;
  logic [DW-1:0] res_a, res_b;
  logic          bad_combo;

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 1'b0;

  always #4 clk = ~clk;

  hom_fetch i_hom_fetch (
    .clk(clk), .rst_n(rst_n), .op_a(op_a), .op_b(op_b), .fw_code(fw_code),
    .sel_a(sel_a), .sel_b(sel_b), .strict(strict),
    .res_a(res_a), .res_b(res_b), .bad_combo(bad_combo)
  );

  function automatic logic [DW-1:0] model(input logic [DW-1:0] v, input logic [1:0] s,
                                          input logic [2:0] c);
    logic [DW-1:0] r;
    int w, h;
    if (c == 3'd0 || s == 2'd0 || s == 2'd3) return v;
    w = 1 << c;
    h = w / 2;
    r = '0;
    for (int i = 0; i < DW; i++) begin
      if ((i % w) < h) r[i] = (s == 2'd1) ? v[i + h] : v[i];
    end
    return r;
  endfunction

  function automatic logic model_bad(input logic [1:0] a, input logic [1:0] b, input logic st);
    return st && (a == 2'd2 || b == 2'd1);
  endfunction

  function automatic string tag_of(input logic [1:0] s, input logic [2:0] c, input logic bad);
    if (bad) return "R9";
    if (c == 3'd0) return "R6";
    if (s == 2'd1) return (c == 3'd7) ? "R10" : "R4";
    if (s == 2'd2) return "R5";
    return "R3";
  endfunction

  task automatic chk_vec(input string tag, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic chk_bit(input string tag, input logic act, input logic exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %b expected %b", tag, act, exp);
    end
  endtask

  // Drive at negedge, check at the following negedge (one register on the way).
  task automatic run_one(input logic [DW-1:0] a, input logic [DW-1:0] b, input logic [2:0] c,
                         input logic [1:0] sa, input logic [1:0] sb, input logic st);
    logic bad;
    op_a = a; op_b = b; fw_code = c; sel_a = sa; sel_b = sb; strict = st;
    bad = model_bad(sa, sb, st);
    @(negedge clk);
    chk_vec(tag_of(sa, c, bad), res_a, bad ? a : model(a, sa, c));
    chk_vec(tag_of(sb, c, bad), res_b, bad ? b : model(b, sb, c));
    chk_bit(st ? "R8" : "R7", bad_combo, bad);
  endtask

  function automatic logic [DW-1:0] rnd128();
    return {$urandom, $urandom, $urandom, $urandom};
  endfunction

  initial begin
    #(8ns * 200000);
    if (!done) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    logic [DW-1:0] pa, pb;
    void'($urandom(32'h1234_5678));
    rst_n = 1'b0;
    op_a = {DW{1'b1}}; op_b = {DW{1'b1}}; fw_code = 3'd3;
    sel_a = 2'd1; sel_b = 2'd2; strict = 1'b0;
    repeat (3) @(negedge clk);
    // R1: reset state
    chk_vec("R1", res_a, '0);
    chk_vec("R1", res_b, '0);
    chk_bit("R1", bad_combo, 1'b0);
    rst_n = 1'b1;
    @(negedge clk);

    // R2: latency - values hold until the next rising edge
    pa = rnd128();
    run_one(pa, ~pa, 3'd2, 2'd0, 2'd0, 1'b0);
    op_a = ~pa; sel_a = 2'd0; fw_code = 3'd2; #1;
    chk_vec("R2", res_a, pa);
    @(negedge clk);
    chk_vec("R2", res_a, ~pa);

    // Directed corner cases
    pa = 128'h0123456789abcdef_fedcba9876543210;
    pb = 128'hdeadbeefcafef00d_0badc0de12345678;
    run_one(pa, pb, 3'd7, 2'd1, 2'd2, 1'b1);   // R10 join halves, strict legal
    run_one(pa, pb, 3'd7, 2'd1, 2'd2, 1'b0);   // R10 full mode
    run_one(pa, pb, 3'd1, 2'd1, 2'd1, 1'b0);   // R7 both upper, 2-bit fields
    run_one(pa, pb, 3'd2, 2'd2, 2'd2, 1'b0);   // R7 both lower, 4-bit fields
    run_one(pa, pb, 3'd1, 2'd1, 2'd1, 1'b1);   // R8 both upper flagged
    run_one(pa, pb, 3'd2, 2'd2, 2'd2, 1'b1);   // R8 both lower flagged
    run_one(pa, pb, 3'd0, 2'd1, 2'd2, 1'b0);   // R6 code 0 no change
    run_one(pa, pb, 3'd5, 2'd3, 2'd0, 1'b0);   // R3 reserved and pass
    run_one({DW{1'b1}}, {DW{1'b1}}, 3'd3, 2'd1, 2'd2, 1'b0); // R4/R5 mask shape

    // Random sweep over all codes and selector pairs
    for (int k = 0; k < 600; k++) begin
      run_one(rnd128(), rnd128(), 3'($urandom_range(0, 7)), 2'($urandom_range(0, 3)),
              2'($urandom_range(0, 3)), 1'($urandom_range(0, 1)));
    end

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end
endmodule